// File: doc/BRIEF.md
# Multi-mode programmable interval counter

One channel of a classic interval timer. A down-counter of `CNT_W` bits (16 by default) moves one step for each cycle in which the count-enable tick is high. A gate input and a single output pin combine in six modes: a timeout, a one-shot started by the gate, a periodic rate generator, a square wave, a strobe started by software, and a strobe started by the gate. Counting runs in plain binary or in packed BCD digits.

The surrounding logic turns host writes into a full count word. It presents that word with a one-cycle load strobe, together with the mode and format bits. Byte sequencing and register decoding stay outside the block. The count, the output pin and a flag showing that a one-shot count is still live are registered outputs.

Top module: `interval_counter`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, out_o is 1, count_o is 0 and loaded_o is 0.
- R2: A clock edge with load_i high captures load_val_i, mode_i and bcd_i. From the next cycle count_o shows the value and loaded_o is 1. A load takes priority over a tick in the same cycle.
- R3: Mode code 0 (timeout). A load drives out_o low. The count steps only on ticks with gate_i high. The tick that brings the count to 0 drives out_o high and clears loaded_o, and out_o then stays high.
- R4: Mode code 1 (gate-started one-shot). After a load, out_o is high and the count holds. On the first tick at or after a rising edge of gate_i, the count is reloaded and out_o goes low. The count then steps on every tick whatever gate_i does, and at 0 out_o goes high and loaded_o clears.
- R5: Mode code 2 (rate generator). On a gated tick, out_o goes low when the count steps to 1. On the next gated tick the count reloads and out_o goes high, so the period is N ticks. A tick with gate_i low holds the count and forces out_o high.
- R6: Mode code 3 (square wave). The count drops by 2 per gated tick and reloads as the half-period ends, at which point out_o toggles. Even N gives N/2 high and N/2 low ticks. Odd N gives (N+1)/2 high and (N-1)/2 low ticks, for N of 2 or more.
- R7: Mode code 4 (software strobe). out_o stays high after a load while the count steps on gated ticks. The tick that reaches 0 drives out_o low and clears loaded_o. The next tick returns out_o high, and there is no reload.
- R8: Mode code 5 (gate-started strobe). A rising gate edge reloads the count on the next tick. The count then steps on every tick even with gate_i low. At 0 out_o is low for one tick and loaded_o clears.
- R9: bcd_i = 1 selects BCD counting, with four bits per decimal digit and the digit at bits 3:0 being least significant. A digit below 0 wraps to 9 and borrows from the next digit; for example, 0x0100 steps to 0x0099.
- R10: A count of 0 stands for the largest count. One step from 0 gives 0xFFFF in binary and 0x9999 in BCD.
- R11: With tick_i and load_i both low, count_o and out_o do not change.
- R12: Mode codes 6 and 7 behave exactly as codes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one counter step per high cycle |
| gate_i | input | 1 | Gate level; rising edges start modes 1 and 5 |
| load_i | input | 1 | Load strobe for count, mode and format |
| load_val_i | input | CNT_W | Count value to load |
| mode_i | input | 3 | Mode code 0..7 |
| bcd_i | input | 1 | 1 = BCD counting, 0 = binary |
| out_o | output | 1 | Output pin |
| count_o | output | CNT_W | Current count |
| loaded_o | output | 1 | 1 while a loaded count has not expired |

## Verification
Every output is a register. A load or a tick therefore shows on count_o, out_o and loaded_o one clock edge after the edge that samples it. A gate edge is seen at the first tick edge at or after the edge where gate_i is first sampled high. The bench holds tick_i high so that one clock is one tick. It changes inputs on the falling edge and reads outputs on the next falling edge, after the edge that acts on them. Each scenario checks the waveform tick by tick against counts worked out from N: the low window of one tick, the reload point and the odd split of the square wave.

// File: rtl/ictr_pkg.sv
package ictr_pkg;
  typedef enum logic [2:0] {
    M_TIMEOUT  = 3'd0,
    M_RETRIG   = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } ictr_mode_e;

  // codes 6/7 fold onto rate and square
  function automatic ictr_mode_e norm_mode(input logic [2:0] code);
    logic [2:0] c;
    c = code[2] & code[1] ? {1'b0, code[1:0]} : code;
    return ictr_mode_e'(c);
  endfunction
endpackage

// File: rtl/ictr_dec.sv
module ictr_dec #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] val_i,
  input  logic             bcd_i,
  input  logic [1:0]       amt_i,
  output logic [CNT_W-1:0] res_o
);
  localparam int DIGITS = CNT_W / 4;

  logic [DIGITS:0]   borrow;
  logic [CNT_W-1:0]  bcd_res;
  logic [CNT_W-1:0]  bin_res;

  assign borrow[0] = 1'b0;
  assign bin_res   = val_i - CNT_W'(amt_i);

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [1:0] sub;
    logic [4:0] diff;
    assign sub  = (g == 0) ? amt_i : 2'd0;
    assign diff = {1'b0, val_i[4*g +: 4]} - {3'b000, sub} - {4'b0000, borrow[g]};
    assign bcd_res[4*g +: 4] = diff[4] ? (diff[3:0] + 4'd10) : diff[3:0];
    assign borrow[g+1]       = diff[4];
  end

  assign res_o = bcd_i ? bcd_res : bin_res;
endmodule

// File: rtl/ictr_gate_edge.sv
module ictr_gate_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic consume_i,
  output logic trig_o
);
  logic gate_q;
  logic pend_q;
  logic rise;

  assign rise   = gate_i & ~gate_q;
  assign trig_o = rise | pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      gate_q <= gate_i;
      pend_q <= trig_o & ~consume_i;
    end
  end

  // R4 an unconsumed rising edge stays pending
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && !gate_q && !consume_i) |=> trig_o);
endmodule

// File: rtl/interval_counter.sv
module interval_counter
  import ictr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [2:0]       mode_i,
  input  logic             bcd_i,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o,
  output logic             loaded_o
);
  localparam int DIGITS = CNT_W / 4;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  ictr_mode_e       mode_q, mode_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, reload_q, reload_n, dec_res;
  logic             bcd_q, bcd_n, out_q, out_n, loaded_q, loaded_n, run_q, run_n;
  logic [1:0]       amt;
  logic             trig;
  logic             sq_end;

  ictr_gate_edge u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gate_i    (gate_i),
    .consume_i (tick_i | load_i),
    .trig_o    (trig)
  );

  ictr_dec #(.CNT_W(CNT_W)) u_dec (
    .val_i (cnt_q),
    .bcd_i (bcd_q),
    .amt_i (amt),
    .res_o (dec_res)
  );

  // square wave: odd count trims 1 in high half, 3 in low half
  always_comb begin
    amt = 2'd1;
    if (mode_q == M_SQUARE) amt = cnt_q[0] ? (out_q ? 2'd1 : 2'd3) : 2'd2;
  end
  assign sq_end = (cnt_q != '0) && (cnt_q <= CNT_W'(amt));

  always_comb begin
    cnt_n    = cnt_q;
    reload_n = reload_q;
    mode_n   = mode_q;
    bcd_n    = bcd_q;
    out_n    = out_q;
    loaded_n = loaded_q;
    run_n    = run_q;
    if (load_i) begin
      cnt_n    = load_val_i;
      reload_n = load_val_i;
      mode_n   = norm_mode(mode_i);
      bcd_n    = bcd_i;
      loaded_n = 1'b1;
      run_n    = 1'b0;
      out_n    = (norm_mode(mode_i) != M_TIMEOUT);
    end else if (tick_i) begin
      case (mode_q)
        M_TIMEOUT: if (gate_i) begin
          cnt_n = dec_res;
          if (loaded_q && dec_res == '0) begin
            out_n    = 1'b1;
            loaded_n = 1'b0;
          end
        end
        M_RETRIG: begin
          if (trig) begin
            cnt_n    = reload_q;
            out_n    = 1'b0;
            run_n    = 1'b1;
            loaded_n = 1'b1;
          end else if (run_q) begin
            cnt_n = dec_res;
            if (dec_res == '0) begin
              out_n    = 1'b1;
              run_n    = 1'b0;
              loaded_n = 1'b0;
            end
          end
        end
        M_RATE: begin
          if (!gate_i) out_n = 1'b1;
          else if (cnt_q == ONE) begin
            cnt_n = reload_q;
            out_n = 1'b1;
          end else begin
            cnt_n = dec_res;
            if (dec_res == ONE) out_n = 1'b0;
          end
        end
        M_SQUARE: if (gate_i) begin
          if (sq_end) begin
            cnt_n = reload_q;
            out_n = ~out_q;
          end else cnt_n = dec_res;
        end
        M_SWSTROBE: begin
          if (!out_q) out_n = 1'b1;
          if (gate_i) begin
            cnt_n = dec_res;
            if (loaded_q && dec_res == '0) begin
              out_n    = 1'b0;
              loaded_n = 1'b0;
            end
          end
        end
        M_HWSTROBE: begin
          if (!out_q) out_n = 1'b1;
          if (trig) begin
            cnt_n    = reload_q;
            run_n    = 1'b1;
            loaded_n = 1'b1;
          end else if (run_q) begin
            cnt_n = dec_res;
            if (dec_res == '0) begin
              out_n    = 1'b0;
              run_n    = 1'b0;
              loaded_n = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
      mode_q   <= M_TIMEOUT;
      bcd_q    <= 1'b0;
      out_q    <= 1'b1;
      loaded_q <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      reload_q <= reload_n;
      mode_q   <= mode_n;
      bcd_q    <= bcd_n;
      out_q    <= out_n;
      loaded_q <= loaded_n;
      run_q    <= run_n;
    end
  end

  assign out_o    = out_q;
  assign count_o  = cnt_q;
  assign loaded_o = loaded_q;

  function automatic logic bcd_ok(input logic [CNT_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R3
  timeout_load_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && mode_i == 3'd0) |=> !out_o);
  // R3
  timeout_rise_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(out_q) && mode_q == M_TIMEOUT) |-> !loaded_q);
  // R5
  rate_gate_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && mode_q == M_RATE && !gate_i) |=> out_o);
  // R7
  strobe_expire_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(loaded_q) && mode_q == M_SWSTROBE) |-> !out_q);
  // R9
  bcd_digit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcd_q && bcd_ok(cnt_q)) |-> bcd_ok(dec_res));
  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> ($stable(cnt_q) && $stable(out_q)));
endmodule

// File: tb/interval_counter_tb_top.sv
module interval_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni, tick_i, gate_i, load_i, bcd_i;
  logic [15:0] load_val_i;
  logic [2:0]  mode_i;
  logic        out_o, loaded_o;
  logic [15:0] count_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_counter dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .gate_i(gate_i),
    .load_i(load_i), .load_val_i(load_val_i), .mode_i(mode_i), .bcd_i(bcd_i),
    .out_o(out_o), .count_o(count_o), .loaded_o(loaded_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input logic [2:0] m, input logic b, input logic [15:0] v);
    mode_i = m; bcd_i = b; load_val_i = v; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic test_reset();
    chk("R1 out", {15'd0, out_o}, 16'd1);
    chk("R1 count", count_o, 16'd0);
    chk("R1 loaded", {15'd0, loaded_o}, 16'd0);
  endtask

  task automatic test_timeout();
    gate_i = 1'b1;
    do_load(3'd0, 1'b0, 16'd3);
    chk("R2 count after load", count_o, 16'd3);
    chk("R2 loaded", {15'd0, loaded_o}, 16'd1);
    chk("R3 out low after load", {15'd0, out_o}, 16'd0);
    gate_i = 1'b0; ticks(2);
    chk("R3 gate low holds", count_o, 16'd3);
    gate_i = 1'b1; ticks(2);
    chk("R3 count", count_o, 16'd1);
    chk("R3 out still low", {15'd0, out_o}, 16'd0);
    ticks(1);
    chk("R3 out high at zero", {15'd0, out_o}, 16'd1);
    chk("R3 expired", {15'd0, loaded_o}, 16'd0);
    ticks(2);
    chk("R3 out stays high", {15'd0, out_o}, 16'd1);
  endtask

  task automatic test_retrig();
    gate_i = 1'b0;
    do_load(3'd1, 1'b0, 16'd3);
    ticks(2);
    chk("R4 idle count", count_o, 16'd3);
    chk("R4 idle out", {15'd0, out_o}, 16'd1);
    gate_i = 1'b1; ticks(1);
    chk("R4 trigger out low", {15'd0, out_o}, 16'd0);
    chk("R4 trigger count", count_o, 16'd3);
    gate_i = 1'b0; ticks(2);
    chk("R4 counts with gate low", count_o, 16'd1);
    chk("R4 out low running", {15'd0, out_o}, 16'd0);
    ticks(1);
    chk("R4 out high at zero", {15'd0, out_o}, 16'd1);
    chk("R4 expired", {15'd0, loaded_o}, 16'd0);
  endtask

  task automatic test_rate(input logic [2:0] code, input string req);
    gate_i = 1'b1;
    do_load(code, 1'b0, 16'd3);
    ticks(1);
    chk({req, " step"}, count_o, 16'd2);
    chk({req, " out high"}, {15'd0, out_o}, 16'd1);
    ticks(1);
    chk({req, " low at one"}, {15'd0, out_o}, 16'd0);
    ticks(1);
    chk({req, " reload"}, count_o, 16'd3);
    chk({req, " out back high"}, {15'd0, out_o}, 16'd1);
    ticks(2);
    chk({req, " second low"}, {15'd0, out_o}, 16'd0);
    gate_i = 1'b0; ticks(1);
    chk({req, " gate low forces high"}, {15'd0, out_o}, 16'd1);
    chk({req, " gate low holds"}, count_o, 16'd1);
    chk({req, " periodic stays loaded"}, {15'd0, loaded_o}, 16'd1);
  endtask

  task automatic test_square(input logic [2:0] code, input logic [15:0] n, input string req);
    int hi = 0;
    int lo = 0;
    gate_i = 1'b1;
    do_load(code, 1'b0, n);
    for (int i = 0; i < int'(n); i++) begin
      if (out_o) hi++; else lo++;
      ticks(1);
    end
    chk({req, " high ticks"}, 16'(hi), 16'((int'(n) + 1) / 2));
    chk({req, " low ticks"}, 16'(lo), 16'(int'(n) / 2));
    chk({req, " out high after period"}, {15'd0, out_o}, 16'd1);
  endtask

  task automatic test_swstrobe();
    gate_i = 1'b1;
    do_load(3'd4, 1'b0, 16'd2);
    chk("R7 out high after load", {15'd0, out_o}, 16'd1);
    gate_i = 1'b0; ticks(1);
    chk("R7 gate low holds", count_o, 16'd2);
    gate_i = 1'b1; ticks(1);
    chk("R7 count", count_o, 16'd1);
    ticks(1);
    chk("R7 low at zero", {15'd0, out_o}, 16'd0);
    chk("R7 expired", {15'd0, loaded_o}, 16'd0);
    ticks(1);
    chk("R7 out back high", {15'd0, out_o}, 16'd1);
    ticks(3);
    chk("R7 no second pulse", {15'd0, out_o}, 16'd1);
  endtask

  task automatic test_hwstrobe();
    gate_i = 1'b0;
    do_load(3'd5, 1'b0, 16'd2);
    ticks(1);
    chk("R8 idle count", count_o, 16'd2);
    gate_i = 1'b1; ticks(1);
    chk("R8 trigger out high", {15'd0, out_o}, 16'd1);
    chk("R8 trigger reload", count_o, 16'd2);
    gate_i = 1'b0; ticks(1);
    chk("R8 counts with gate low", count_o, 16'd1);
    ticks(1);
    chk("R8 low at zero", {15'd0, out_o}, 16'd0);
    chk("R8 expired", {15'd0, loaded_o}, 16'd0);
    ticks(1);
    chk("R8 out back high", {15'd0, out_o}, 16'd1);
  endtask

  task automatic test_formats();
    gate_i = 1'b1;
    do_load(3'd0, 1'b1, 16'h0100);
    ticks(1);
    chk("R9 bcd borrow", count_o, 16'h0099);
    ticks(1);
    chk("R9 bcd step", count_o, 16'h0098);
    do_load(3'd0, 1'b1, 16'h0000);
    ticks(1);
    chk("R10 bcd zero is max", count_o, 16'h9999);
    do_load(3'd0, 1'b0, 16'h0000);
    ticks(1);
    chk("R10 binary zero is max", count_o, 16'hFFFF);
    chk("R10 zero not expired", {15'd0, loaded_o}, 16'd1);
  endtask

  task automatic test_idle();
    gate_i = 1'b1;
    tick_i = 1'b0;
    do_load(3'd0, 1'b0, 16'd5);
    chk("R2 load without tick", count_o, 16'd5);
    ticks(3);
    chk("R11 count holds", count_o, 16'd5);
    chk("R11 out holds", {15'd0, out_o}, 16'd0);
    tick_i = 1'b1;
    ticks(1);
    chk("R11 resumes", count_o, 16'd4);
  endtask

  initial begin
    rst_ni = 1'b0; tick_i = 1'b0; gate_i = 1'b0; load_i = 1'b0;
    bcd_i = 1'b0; load_val_i = '0; mode_i = '0;
    ticks(3);
    test_reset();
    rst_ni = 1'b1;
    ticks(1);
    test_reset();
    tick_i = 1'b1;
    test_timeout();
    test_retrig();
    test_rate(3'd2, "R5");
    test_rate(3'd6, "R12");
    test_square(3'd3, 16'd5, "R6 odd");
    test_square(3'd3, 16'd4, "R6 even");
    test_square(3'd7, 16'd6, "R12 square alias");
    test_swstrobe();
    test_hwstrobe();
    test_formats();
    test_idle();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule